// File: doc/BRIEF.md
# Intel Hex Record Parser

This block turns an ASCII stream of Intel Hex records into a stream of absolute-addressed data bytes. Characters arrive one per handshake. The block pairs hex digits into bytes and checks each record's checksum. It keeps the upper address state that extended-address records set. For every data byte of a good data record, it emits the byte together with its full 32-bit address. A separate one-cycle pulse marks an end-of-file record, and another marks a record that was rejected.

The byte address is formed as (linear base shifted left 16) plus (segment base shifted left 4) plus the record's 16-bit offset. It advances by one for each later byte of the same record and wraps at 32 bits. The data bytes of a record are held in an internal buffer until the checksum has been verified, so that nothing from a corrupt record ever reaches the output.

Both streams use valid/ready. An input character is taken on a clock edge where `ch_valid` and `ch_ready` are both high. An output byte is taken on an edge where `byte_valid` and `byte_ready` are both high. The parser stops taking characters while it drains the buffered bytes of a data record, so back-pressure on the output propagates to the input. Once `byte_valid` is high, it stays high with a stable address and value until the byte is taken.

Top module: `ihex_parser`

## Requirements
- R1: After reset, `ch_ready` is 1 and `byte_valid`, `eof_pulse` and `rec_error` are 0. Both base values start at zero.
- R2: A record is ':' followed by hex-digit pairs. The pairs are, in order: byte count, offset high, offset low, type, the data bytes, and the checksum. A type 00 record with a good checksum emits its data bytes in arrival order. The first byte is at address linear*65536 + segment*16 + offset, and each following byte is at the previous address plus 1 (modulo 2^32).
- R3: A record passes only if the 8-bit sum of every decoded byte after ':' is 0x00, checksum included. A failing record pulses `rec_error` in the cycle after its last checksum digit is accepted, and it emits no byte.
- R4: A good type 04 record with byte count 2 sets the linear base to its two data bytes (first byte high). The value holds for all later data records until another such record arrives.
- R5: A good type 02 record with byte count 2 sets the segment base to its two data bytes (first byte high). The value holds until it is replaced.
- R6: A good type 01 record pulses `eof_pulse` for exactly one cycle, in the cycle after its last checksum digit is accepted.
- R7: Good type 03 and type 05 records produce no byte, no error and no end-of-file pulse, and they leave both bases unchanged.
- R8: The hex digits 0-9, A-F and a-f are all accepted, and upper and lower case decode to the same value.
- R9: Any character other than a hex digit that arrives after ':' and before the record is complete pulses `rec_error` in the next cycle and discards the record. Characters other than ':' that arrive between records (CR, LF or anything else) are ignored.
- R10: While `byte_valid` is 1, `ch_ready` is 0. If `byte_valid` is 1 and `byte_ready` is 0, the next cycle shows the same `byte_addr` and `byte_data` with `byte_valid` still 1.
- R11: A byte count greater than the parameter MAX_BYTES pulses `rec_error` and discards the record. The rest of the record's characters are ignored.
- R12: A record of type 06 or higher, or a type 02 or 04 record whose byte count is not 2, pulses `rec_error` and changes no base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_valid | input | 1 | Input character present |
| ch_ready | output | 1 | Parser can take a character |
| ch_data | input | 8 | ASCII character |
| byte_valid | output | 1 | Output byte present |
| byte_ready | input | 1 | Consumer takes the output byte |
| byte_addr | output | 32 | Absolute address of the output byte |
| byte_data | output | 8 | Output data byte |
| eof_pulse | output | 1 | One-cycle pulse for a good end-of-file record |
| rec_error | output | 1 | One-cycle pulse for a rejected record |

## Verification
The bench builds the parser with MAX_BYTES set to 16. This keeps the byte buffer small and makes the oversize-count rejection reachable with a 17-byte record, which could not happen at the default of 255. A 16-byte record at an offset near 0xFFFF is drained under pseudo-random output stalls, which exercises the hold rule and the carry of the address sum past the record's 16-bit offset.

// File: rtl/ihex_pkg.sv
package ihex_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_REC, ST_DRAIN} pstate_t;

  typedef struct packed {
    logic       ok;
    logic [3:0] val;
  } nib_t;

  localparam logic [7:0] CH_COLON = 8'h3A;

  localparam logic [7:0] RT_DATA = 8'h00;
  localparam logic [7:0] RT_EOF  = 8'h01;
  localparam logic [7:0] RT_SEG  = 8'h02;
  localparam logic [7:0] RT_SSEG = 8'h03;
  localparam logic [7:0] RT_LIN  = 8'h04;
  localparam logic [7:0] RT_SLIN = 8'h05;

  // ASCII hex digit to nibble; ok is clear for anything else
  function automatic nib_t hex_decode(input logic [7:0] c);
    nib_t r;
    r.ok  = 1'b1;
    r.val = 4'h0;
    if (c >= 8'h30 && c <= 8'h39)      r.val = 4'(c - 8'h30);
    else if (c >= 8'h41 && c <= 8'h46) r.val = 4'(c - 8'h37);
    else if (c >= 8'h61 && c <= 8'h66) r.val = 4'(c - 8'h57);
    else                               r.ok  = 1'b0;
    return r;
  endfunction

endpackage

// File: rtl/ihex_bytebuf.sv
module ihex_bytebuf #(
  parameter int DEPTH = 255,
  parameter int IX_W  = 8
) (
  input  logic            clk,
  input  logic            wr_en,
  input  logic [IX_W-1:0] wr_idx,
  input  logic [7:0]      wr_byte,
  input  logic [IX_W-1:0] rd_idx,
  output logic [7:0]      rd_byte
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_byte;
  end

  assign rd_byte = mem[rd_idx];
endmodule

// File: rtl/ihex_addrgen.sv
module ihex_addrgen (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        set_seg,
  input  logic        set_lin,
  input  logic [15:0] ext_val,
  input  logic        load,
  input  logic [15:0] offs,
  input  logic        step,
  output logic [31:0] addr
);
  logic [15:0] lin_q, seg_q;
  logic [31:0] cur_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lin_q <= '0;
      seg_q <= '0;
      cur_q <= '0;
    end else begin
      if (set_lin) lin_q <= ext_val;
      if (set_seg) seg_q <= ext_val;
      if (load)
        cur_q <= {lin_q, 16'h0000} + {12'h000, seg_q, 4'h0} + {16'h0000, offs};
      else if (step)
        cur_q <= cur_q + 32'd1;
    end
  end

  assign addr = cur_q;
endmodule

// File: rtl/ihex_frame.sv
module ihex_frame
  import ihex_pkg::*;
#(
  parameter int MAX_BYTES = 255,
  parameter int IX_W      = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ch_valid,
  output logic            ch_ready,
  input  logic [7:0]      ch_data,
  output logic            out_valid,
  input  logic            out_ready,
  output logic            wr_en,
  output logic [IX_W-1:0] wr_idx,
  output logic [7:0]      wr_byte,
  output logic [IX_W-1:0] rd_idx,
  output logic            load,
  output logic            step,
  output logic [15:0]     offs,
  output logic            set_seg,
  output logic            set_lin,
  output logic [15:0]     ext_val,
  output logic            eof_pulse,
  output logic            rec_error
);
  localparam int POS_W = 9;  // byte position after ':' reaches count + 4 <= 259

  pstate_t        state;
  logic           half;
  logic [3:0]     hi_nib;
  logic [POS_W-1:0] pos;
  logic [7:0]     cnt, rtype, sum;
  logic [15:0]    offs_q, ext_q;
  logic [IX_W-1:0] rd_q;
  logic           eof_q, err_q;

  nib_t           dec;
  logic           acc, digit_acc, in_data, fin, cs_good, too_big, rd_last;
  logic [7:0]     cur_byte;
  logic [POS_W-1:0] end_pos;

  always_comb begin
    dec       = hex_decode(ch_data);
    cur_byte  = {hi_nib, dec.val};
    acc       = ch_valid && ch_ready;
    digit_acc = acc && (state == ST_REC) && dec.ok && half;
    end_pos   = {1'b0, cnt} + POS_W'(4);
    in_data   = (pos >= POS_W'(4)) && (pos < end_pos);
    fin       = digit_acc && (pos == end_pos);
    cs_good   = (8'(sum + cur_byte) == 8'h00);
    too_big   = int'(cur_byte) > MAX_BYTES;
    rd_last   = (8'(rd_q) == 8'(cnt - 8'd1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      half   <= 1'b0;
      hi_nib <= '0;
      pos    <= '0;
      cnt    <= '0;
      rtype  <= '0;
      sum    <= '0;
      offs_q <= '0;
      ext_q  <= '0;
      rd_q   <= '0;
      eof_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      eof_q <= 1'b0;
      err_q <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (acc && ch_data == CH_COLON) begin
            state <= ST_REC;
            half  <= 1'b0;
            pos   <= '0;
            sum   <= '0;
          end
        end
        ST_REC: begin
          if (acc) begin
            if (!dec.ok) begin
              err_q <= 1'b1;
              state <= ST_IDLE;
            end else if (!half) begin
              hi_nib <= dec.val;
              half   <= 1'b1;
            end else begin
              half <= 1'b0;
              pos  <= pos + POS_W'(1);
              sum  <= sum + cur_byte;
              if (pos == POS_W'(0)) begin
                cnt <= cur_byte;
                if (too_big) begin
                  err_q <= 1'b1;
                  state <= ST_IDLE;
                end
              end
              if (pos == POS_W'(1)) offs_q[15:8] <= cur_byte;
              if (pos == POS_W'(2)) offs_q[7:0]  <= cur_byte;
              if (pos == POS_W'(3)) rtype        <= cur_byte;
              if (pos == POS_W'(4)) ext_q[15:8]  <= cur_byte;
              if (pos == POS_W'(5)) ext_q[7:0]   <= cur_byte;
              if (fin) begin
                state <= ST_IDLE;
                if (!cs_good) begin
                  err_q <= 1'b1;
                end else begin
                  case (rtype)
                    RT_DATA: if (cnt != 8'd0) begin
                      state <= ST_DRAIN;
                      rd_q  <= '0;
                    end
                    RT_EOF:          eof_q <= 1'b1;
                    RT_SEG, RT_LIN:  if (cnt != 8'd2) err_q <= 1'b1;
                    RT_SSEG, RT_SLIN: ;
                    default:         err_q <= 1'b1;
                  endcase
                end
              end
            end
          end
        end
        ST_DRAIN: begin
          if (out_ready) begin
            rd_q <= rd_q + IX_W'(1);
            if (rd_last) state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign ch_ready  = (state != ST_DRAIN);
  assign out_valid = (state == ST_DRAIN);
  assign wr_en     = digit_acc && in_data;
  assign wr_idx    = IX_W'(pos - POS_W'(4));
  assign wr_byte   = cur_byte;
  assign rd_idx    = rd_q;
  assign step      = out_valid && out_ready;
  assign load      = fin && cs_good && (rtype == RT_DATA) && (cnt != 8'd0);
  assign set_seg   = fin && cs_good && (rtype == RT_SEG) && (cnt == 8'd2);
  assign set_lin   = fin && cs_good && (rtype == RT_LIN) && (cnt == 8'd2);
  assign offs      = offs_q;
  assign ext_val   = ext_q;
  assign eof_pulse = eof_q;
  assign rec_error = err_q;
endmodule

// File: rtl/ihex_parser.sv
module ihex_parser #(
  parameter int MAX_BYTES = 255
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ch_valid,
  output logic        ch_ready,
  input  logic [7:0]  ch_data,
  output logic        byte_valid,
  input  logic        byte_ready,
  output logic [31:0] byte_addr,
  output logic [7:0]  byte_data,
  output logic        eof_pulse,
  output logic        rec_error
);
  localparam int IX_W = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1;

  logic            wr_en, load, step, set_seg, set_lin;
  logic [IX_W-1:0] wr_idx, rd_idx;
  logic [7:0]      wr_byte;
  logic [15:0]     offs, ext_val;

  ihex_frame #(.MAX_BYTES(MAX_BYTES), .IX_W(IX_W)) u_frame (
    .clk(clk), .rst_n(rst_n),
    .ch_valid(ch_valid), .ch_ready(ch_ready), .ch_data(ch_data),
    .out_valid(byte_valid), .out_ready(byte_ready),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_byte(wr_byte), .rd_idx(rd_idx),
    .load(load), .step(step), .offs(offs),
    .set_seg(set_seg), .set_lin(set_lin), .ext_val(ext_val),
    .eof_pulse(eof_pulse), .rec_error(rec_error)
  );

  ihex_bytebuf #(.DEPTH(MAX_BYTES), .IX_W(IX_W)) u_buf (
    .clk(clk), .wr_en(wr_en), .wr_idx(wr_idx), .wr_byte(wr_byte),
    .rd_idx(rd_idx), .rd_byte(byte_data)
  );

  ihex_addrgen u_addr (
    .clk(clk), .rst_n(rst_n),
    .set_seg(set_seg), .set_lin(set_lin), .ext_val(ext_val),
    .load(load), .offs(offs), .step(step), .addr(byte_addr)
  );
endmodule

// File: rtl/ihex_parser_chk.sv
module ihex_parser_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ch_ready,
  input logic        byte_valid,
  input logic        byte_ready,
  input logic [31:0] byte_addr,
  input logic [7:0]  byte_data,
  input logic        eof_pulse,
  input logic        rec_error
);
  // R10
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid && !byte_ready |=> byte_valid && $stable(byte_addr) && $stable(byte_data));

  // R10
  input_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> !ch_ready);

  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid && byte_ready |=> !byte_valid || (byte_addr == $past(byte_addr) + 32'd1));

  // R6
  eof_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eof_pulse |=> !eof_pulse);

  // R3
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_error |-> !byte_valid && !eof_pulse);
endmodule

bind ihex_parser ihex_parser_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ch_ready(ch_ready),
  .byte_valid(byte_valid), .byte_ready(byte_ready),
  .byte_addr(byte_addr), .byte_data(byte_data),
  .eof_pulse(eof_pulse), .rec_error(rec_error)
);

// File: tb/ihex_parser_bench.sv
module ihex_parser_bench;
  localparam int CLK_P = 10;
  localparam int MAXB  = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ch_valid, ch_ready;
  logic [7:0]  ch_data;
  logic        byte_valid, byte_ready;
  logic [31:0] byte_addr;
  logic [7:0]  byte_data;
  logic        eof_pulse, rec_error;

  always #(CLK_P/2) clk = ~clk;

  ihex_parser #(.MAX_BYTES(MAXB)) u_ihex_parser (
    .clk(clk), .rst_n(rst_n),
    .ch_valid(ch_valid), .ch_ready(ch_ready), .ch_data(ch_data),
    .byte_valid(byte_valid), .byte_ready(byte_ready),
    .byte_addr(byte_addr), .byte_data(byte_data),
    .eof_pulse(eof_pulse), .rec_error(rec_error)
  );

  logic [39:0] exp_q[$];
  string       tag_q[$];
  int          n_chk = 0, n_fail = 0;
  int          err_seen = 0, eof_seen = 0;
  bit          done = 1'b0;
  bit          lower = 1'b0;
  bit          bp_mode = 1'b0;
  logic [7:0]  lfsr = 8'h5A;
  logic [7:0]  rec_buf [0:31];
  logic [7:0]  cs_acc;
  logic [15:0] m_lin = 16'h0, m_seg = 16'h0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  function automatic logic [7:0] hexch(input logic [3:0] n);
    if (n < 4'd10) return 8'h30 + 8'(n);
    return (lower ? 8'h61 : 8'h41) + 8'(n) - 8'd10;
  endfunction

  // called at a falling edge, returns at the falling edge after acceptance
  task automatic send_char(input logic [7:0] c);
    bit ok;
    ch_data  = c;
    ch_valid = 1'b1;
    forever begin
      #(CLK_P/4);
      ok = ch_ready;
      @(negedge clk);
      if (ok) break;
    end
    ch_valid = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    cs_acc = cs_acc + b;
    send_char(hexch(b[7:4]));
    send_char(hexch(b[3:0]));
  endtask

  task automatic send_record(input logic [7:0] cnt, input logic [15:0] off,
                             input logic [7:0] typ, input int ndat,
                             input logic [7:0] cs_flip);
    cs_acc = 8'h00;
    send_char(8'h3A);
    send_byte(cnt);
    send_byte(off[15:8]);
    send_byte(off[7:0]);
    send_byte(typ);
    for (int i = 0; i < ndat; i++) send_byte(rec_buf[i]);
    send_byte((8'h00 - cs_acc) ^ cs_flip);
  endtask

  task automatic crlf();
    send_char(8'h0D);
    send_char(8'h0A);
  endtask

  task automatic expect_data(input logic [15:0] off, input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back({{m_lin, 16'h0} + {12'h0, m_seg, 4'h0} + {16'h0, off} + 32'(i),
                       rec_buf[i]});
      tag_q.push_back(tag);
    end
  endtask

  task automatic wait_drain(input string req);
    int t = 0;
    while (exp_q.size() != 0 && t < 3000) begin
      @(negedge clk);
      t++;
    end
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, req, "bytes still expected", 32'(exp_q.size()), 0);
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  // output back-pressure source
  initial begin
    byte_ready = 1'b1;
    forever begin
      @(negedge clk);
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      byte_ready = !bp_mode || lfsr[0];
    end
  end

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_P/4);
      if (rst_n) begin
        if (byte_valid) begin
          chk(!ch_ready, "R10", "input ready while draining", 32'(ch_ready), 0);
          if (byte_ready) begin
            if (exp_q.size() == 0) begin
              chk(1'b0, "R3", "unexpected output byte", byte_addr, 0);
            end else begin
              logic [39:0] e;
              string tg;
              e  = exp_q.pop_front();
              tg = tag_q.pop_front();
              chk(byte_addr == e[39:8], tg, "byte address", byte_addr, e[39:8]);
              chk(byte_data == e[7:0], tg, "byte value", 32'(byte_data), 32'(e[7:0]));
            end
          end
        end
        if (eof_pulse) eof_seen++;
        if (rec_error) err_seen++;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R2 watchdog expired: actual %0d expected %0d", 1, 0);
    finish_up();
  end

  initial begin
    int e0, f0;
    rst_n    = 1'b0;
    ch_valid = 1'b0;
    ch_data  = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #(CLK_P/4);
    // R1 reset state
    chk(ch_ready == 1'b1, "R1", "ch_ready", 32'(ch_ready), 1);
    chk(byte_valid == 1'b0, "R1", "byte_valid", 32'(byte_valid), 0);
    chk(eof_pulse == 1'b0, "R1", "eof_pulse", 32'(eof_pulse), 0);
    chk(rec_error == 1'b0, "R1", "rec_error", 32'(rec_error), 0);
    @(negedge clk);

    // R2 plain data record with zero bases
    rec_buf[0] = 8'h90; rec_buf[1] = 8'hFF; rec_buf[2] = 8'hAA; rec_buf[3] = 8'h55;
    expect_data(16'h0100, 4, "R2");
    send_record(8'd4, 16'h0100, 8'h00, 4, 8'h00);
    crlf();
    wait_drain("R2");

    // R4 linear base, R5 segment base
    e0 = err_seen;
    rec_buf[0] = 8'h01; rec_buf[1] = 8'h08;
    send_record(8'd2, 16'h0000, 8'h04, 2, 8'h00);
    crlf();
    m_lin = 16'h0108;
    rec_buf[0] = 8'h12; rec_buf[1] = 8'hFF;
    send_record(8'd2, 16'h0000, 8'h02, 2, 8'h00);
    crlf();
    m_seg = 16'h12FF;
    settle();
    chk(err_seen == e0, "R4", "errors on base records", 32'(err_seen - e0), 0);
    rec_buf[0] = 8'h90; rec_buf[1] = 8'hFF; rec_buf[2] = 8'hAA; rec_buf[3] = 8'h55;
    expect_data(16'h0100, 4, "R5");
    send_record(8'd4, 16'h0100, 8'h00, 4, 8'h00);
    crlf();
    wait_drain("R5");

    // R10 full-size record under stalls; bases persist (R4)
    bp_mode = 1'b1;
    for (int i = 0; i < 16; i++) rec_buf[i] = 8'(i * 7 + 3);
    expect_data(16'hFFF8, 16, "R10");
    send_record(8'd16, 16'hFFF8, 8'h00, 16, 8'h00);
    crlf();
    wait_drain("R10");
    bp_mode = 1'b0;

    // R3 bad checksum
    e0 = err_seen;
    rec_buf[0] = 8'h11; rec_buf[1] = 8'h22; rec_buf[2] = 8'h33;
    send_record(8'd3, 16'h0040, 8'h00, 3, 8'h01);
    #(CLK_P/4);
    chk(rec_error == 1'b1, "R3", "error pulse after checksum", 32'(rec_error), 1);
    @(negedge clk);
    crlf();
    settle();
    chk(err_seen == e0 + 1, "R3", "error count", 32'(err_seen - e0), 1);
    chk(exp_q.size() == 0, "R3", "queue after bad record", 32'(exp_q.size()), 0);

    // R8 lower-case digits
    lower = 1'b1;
    rec_buf[0] = 8'hAB; rec_buf[1] = 8'hCD; rec_buf[2] = 8'hEF; rec_buf[3] = 8'h9A;
    expect_data(16'h0020, 4, "R8");
    send_record(8'd4, 16'h0020, 8'h00, 4, 8'h00);
    crlf();
    wait_drain("R8");
    lower = 1'b0;

    // R9 bad character inside a record, junk between records
    e0 = err_seen;
    send_char(8'h3A);
    send_char(8'h30);
    send_char(8'h32);
    send_char(8'h47);
    #(CLK_P/4);
    chk(rec_error == 1'b1, "R9", "error pulse on non-hex", 32'(rec_error), 1);
    @(negedge clk);
    send_char(8'h31);
    send_char(8'h78);
    crlf();
    rec_buf[0] = 8'h5C; rec_buf[1] = 8'hC5;
    expect_data(16'h0300, 2, "R9");
    send_record(8'd2, 16'h0300, 8'h00, 2, 8'h00);
    crlf();
    wait_drain("R9");
    chk(err_seen == e0 + 1, "R9", "error count", 32'(err_seen - e0), 1);

    // R7 start-address records are inert
    e0 = err_seen; f0 = eof_seen;
    rec_buf[0] = 8'h00; rec_buf[1] = 8'h00; rec_buf[2] = 8'h12; rec_buf[3] = 8'h34;
    send_record(8'd4, 16'h0000, 8'h03, 4, 8'h00);
    crlf();
    send_record(8'd4, 16'h0000, 8'h05, 4, 8'h00);
    crlf();
    settle();
    chk(err_seen == e0, "R7", "errors", 32'(err_seen - e0), 0);
    chk(eof_seen == f0, "R7", "eof pulses", 32'(eof_seen - f0), 0);
    rec_buf[0] = 8'h77;
    expect_data(16'h0000, 1, "R7");
    send_record(8'd1, 16'h0000, 8'h00, 1, 8'h00);
    crlf();
    wait_drain("R7");

    // R11 oversize count
    e0 = err_seen;
    for (int i = 0; i < 17; i++) rec_buf[i] = 8'(i);
    send_record(8'd17, 16'h0000, 8'h00, 17, 8'h00);
    crlf();
    settle();
    chk(err_seen == e0 + 1, "R11", "error count", 32'(err_seen - e0), 1);
    chk(exp_q.size() == 0 && !byte_valid, "R11", "no output", 32'(byte_valid), 0);

    // R12 unknown type and malformed base record
    e0 = err_seen;
    send_record(8'd0, 16'h0000, 8'h06, 0, 8'h00);
    crlf();
    rec_buf[0] = 8'hEE;
    send_record(8'd1, 16'h0000, 8'h04, 1, 8'h00);
    crlf();
    settle();
    chk(err_seen == e0 + 2, "R12", "error count", 32'(err_seen - e0), 2);
    rec_buf[0] = 8'h3C;
    expect_data(16'h0010, 1, "R12");
    send_record(8'd1, 16'h0010, 8'h00, 1, 8'h00);
    crlf();
    wait_drain("R12");

    // R6 end of file
    f0 = eof_seen;
    send_record(8'd0, 16'h0000, 8'h01, 0, 8'h00);
    #(CLK_P/4);
    chk(eof_pulse == 1'b1, "R6", "eof pulse", 32'(eof_pulse), 1);
    @(negedge clk);
    #(CLK_P/4);
    chk(eof_pulse == 1'b0, "R6", "eof pulse width", 32'(eof_pulse), 0);
    @(negedge clk);
    crlf();
    settle();
    chk(eof_seen == f0 + 1, "R6", "eof count", 32'(eof_seen - f0), 1);

    finish_up();
  end
endmodule